// File: doc/BRIEF.md
# Multi-Source Parity DMA Datapath

This block carries out one data-movement job per command. A command consists of a 32-bit control word and a byte length. The block decodes the operation from packed fields in the control word and then moves words between streaming ports. There are three kinds of job:

- **Copy** forwards the stream on source port 0 to the destination port.
- **Parity** reads between one and eight source streams for every output word. It combines them with XOR and sends the result to the destination.
- **No-op** moves no data and only signals completion.

Every job ends with a one-cycle completion pulse. The pulse carries a status code and the interrupt-on-done request bit taken from the control word.

The block sits between a descriptor fetcher and the memory read and write engines. The fetcher presents a command with a valid/ready handshake. The read engines supply one word stream per source port, and the write engine drains the destination stream. Address generation and bursts live outside the block.

The control flow is a four-state machine:

- **IDLE** accepts a command.
  - *Dataless accept* leads to **REPORT**. This covers a no-op, a rejected command, an unsupported mode, or a zero length.
  - *Move accept* leads to **GATHER**.
- **GATHER** takes one word from the current source port.
  - *Next source* stays in GATHER.
  - *Last source* goes to **OFFER**.
- **OFFER** presents the word on the destination port.
  - *Word taken, more left* returns to GATHER.
  - *Final word taken* goes to REPORT.
- **REPORT** pulses completion for one cycle.
  - *Report done* returns to IDLE.

Top module: `xor_dma_core`

## Requirements
- R1: The operation is taken from control bits [31:28]. Value 0 is a no-op, 1 is a copy and 6 is a parity job. Every other value (2, 3, 4, 5, 7, 8 and 9..15) completes with status 2'b10 (unsupported), moves no data and reads no source.
- R2: A copy job reads only source port 0 and forwards its words unchanged to the destination. This holds whatever the source-count field contains. All other source ports stay untouched.
- R3: In a parity job, the source count N is read from control bits [25:22]. For every output word the block reads ports 0 to N-1 in ascending order. The XOR of those N words is presented only after all N have been taken. Ports N and above are never read.
- R4: A parity job is rejected in three cases: N is 0, N is above 8, or the parity-output enable bit 17 is clear. A rejected job completes with status 2'b01 and moves no data.
- R5: The length is in bytes. A copy or parity job produces ceil(length/4) destination words. A length of 0 produces no words and completes with status 2'b00.
- R6: Every destination word except the last carries byte strobe 4'hF. The last word carries the low (length mod 4) strobe bits, or 4'hF when the length is a multiple of 4. `dst_last` is high on the last word only.
- R7: A no-op job moves no data, reads no source and completes with status 2'b00.
- R8: `done_pulse` is high for exactly one cycle per job. It rises one cycle after the last destination word is accepted; for a dataless job it rises one cycle after the command is accepted. `done_irq` equals control bit 27 during the pulse and is 0 at all other times.
- R9: While `dst_valid` is high and `dst_ready` is low, the destination data, strobe and last flag hold steady.
- R10: After reset the block is idle. In that state `cmd_ready` is 1, and no destination word, source request or completion is driven. `cmd_ready` is high only while idle.
- R11: At most one `src_ready` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_ctrl | input | 32 | Packed control word |
| cmd_len | input | LEN_W | Job length in bytes |
| src_valid | input | MAX_SRC | Per-port source word present |
| src_data | input | MAX_SRC*DATA_W | Source words, port s at bits [s*DATA_W +: DATA_W] |
| src_ready | output | MAX_SRC | Per-port source word taken |
| dst_valid | output | 1 | Destination word present |
| dst_data | output | DATA_W | Destination word |
| dst_strb | output | DATA_W/8 | Byte strobes of the destination word |
| dst_last | output | 1 | Final word of the job |
| dst_ready | input | 1 | Destination word taken |
| done_pulse | output | 1 | Job completion, one cycle |
| done_irq | output | 1 | Interrupt request of the completed job |
| done_status | output | 2 | 00 ok, 01 rejected configuration, 10 unsupported mode |

## Verification
The assertions assume that the neighbours respect the handshakes. The command stays stable while `cmd_valid` is high and unaccepted, and a source word stays in place until it is taken. The bench keeps to this rule. It changes the command only after seeing `cmd_ready`, and each source port's data depends only on how many words that port has already delivered. The bench also throttles the source valids and the destination ready with fixed cyclic patterns, so that the hold checks and the source-ordering checks are exercised under stalls.

// File: rtl/xdp_pkg.sv
`timescale 1ns/1ps
package xdp_pkg;
    localparam int CTRL_W   = 32;
    localparam int MODE_LSB = 28;
    localparam int IOD_BIT  = 27;
    localparam int CNT_LSB  = 22;
    localparam int CNT_W    = 4;
    localparam int PEN_BIT  = 17;

    localparam logic [3:0] MODE_NOP    = 4'd0;
    localparam logic [3:0] MODE_COPY   = 4'd1;
    localparam logic [3:0] MODE_PARITY = 4'd6;

    typedef enum logic [1:0] {
        ST_OK     = 2'b00,
        ST_BADCFG = 2'b01,
        ST_UNSUP  = 2'b10
    } status_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_MOVE,
        K_BAD,
        K_UNSUP
    } kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_GATHER,
        S_OFFER,
        S_REPORT
    } state_t;
endpackage

// File: rtl/xdp_decode.sv
`timescale 1ns/1ps
module xdp_decode
    import xdp_pkg::*;
#(
    parameter int MAX_SRC = 8
) (
    input  logic [CTRL_W-1:0] ctrl,
    output kind_t             kind,
    output logic [CNT_W-1:0]  nsrc,
    output logic              irq
);
    logic [3:0]       mode;
    logic [CNT_W-1:0] cnt;
    logic             pen;
    logic             unused_bits;

    assign mode        = ctrl[MODE_LSB +: 4];
    assign cnt         = ctrl[CNT_LSB +: CNT_W];
    assign pen         = ctrl[PEN_BIT];
    assign irq         = ctrl[IOD_BIT];
    assign unused_bits = ^{ctrl[26], ctrl[21:18], ctrl[16:0]};

    always_comb begin
        kind = K_UNSUP;
        nsrc = '0;
        unique case (mode)
            MODE_NOP:  kind = K_NONE;
            MODE_COPY: begin
                kind = K_MOVE;
                nsrc = CNT_W'(1);
            end
            MODE_PARITY: begin
                if (pen && cnt != '0 && int'(cnt) <= MAX_SRC) begin
                    kind = K_MOVE;
                    nsrc = cnt;
                end else begin
                    kind = K_BAD;
                end
            end
            default: kind = K_UNSUP;
        endcase
    end
endmodule

// File: rtl/xdp_len_map.sv
`timescale 1ns/1ps
module xdp_len_map #(
    parameter int LEN_W = 16,
    parameter int BYTES = 4
) (
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] words,
    output logic [BYTES-1:0] tail
);
    localparam int OFS = $clog2(BYTES);

    logic [OFS-1:0] rem;
    assign rem   = len[OFS-1:0];
    assign words = (len >> OFS) + LEN_W'(rem != '0);

    for (genvar b = 0; b < BYTES; b++) begin : g_tail
        assign tail[b] = (rem == '0) || (OFS'(b) < rem);
    end
endmodule

// File: rtl/xor_dma_core.sv
`timescale 1ns/1ps
module xor_dma_core
    import xdp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MAX_SRC = 8,
    parameter int LEN_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [31:0]               cmd_ctrl,
    input  logic [LEN_W-1:0]          cmd_len,
    input  logic [MAX_SRC-1:0]        src_valid,
    input  logic [MAX_SRC*DATA_W-1:0] src_data,
    output logic [MAX_SRC-1:0]        src_ready,
    output logic                      dst_valid,
    output logic [DATA_W-1:0]         dst_data,
    output logic [DATA_W/8-1:0]       dst_strb,
    output logic                      dst_last,
    input  logic                      dst_ready,
    output logic                      done_pulse,
    output logic                      done_irq,
    output logic [1:0]                done_status
);
    localparam int BYTES = DATA_W / 8;

    kind_t            dec_kind;
    logic [CNT_W-1:0] dec_nsrc;
    logic             dec_irq;
    logic [LEN_W-1:0] map_words;
    logic [BYTES-1:0] map_tail;

    xdp_decode #(.MAX_SRC(MAX_SRC)) u_dec (
        .ctrl (cmd_ctrl),
        .kind (dec_kind),
        .nsrc (dec_nsrc),
        .irq  (dec_irq)
    );

    xdp_len_map #(.LEN_W(LEN_W), .BYTES(BYTES)) u_len (
        .len   (cmd_len),
        .words (map_words),
        .tail  (map_tail)
    );

    state_t           state_q, state_d;
    logic [DATA_W-1:0] acc_q;
    logic [CNT_W-1:0] idx_q, nsrc_q;
    logic [LEN_W-1:0] left_q;
    logic [BYTES-1:0] tail_q;
    logic             irq_q;
    status_t          stat_q;

    logic [DATA_W-1:0] sel_word;
    logic              src_hit, idx_last, accept;

    for (genvar s = 0; s < MAX_SRC; s++) begin : g_req
        assign src_ready[s] = (state_q == S_GATHER) && (idx_q == CNT_W'(s));
    end

    always_comb begin
        sel_word = '0;
        for (int s = 0; s < MAX_SRC; s++) begin
            if (idx_q == CNT_W'(s)) sel_word = src_data[s*DATA_W +: DATA_W];
        end
    end

    assign src_hit  = |(src_valid & src_ready);
    assign idx_last = (idx_q + CNT_W'(1)) == nsrc_q;
    assign accept   = (state_q == S_IDLE) && cmd_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (cmd_valid) begin
                if (dec_kind == K_MOVE && map_words != '0) state_d = S_GATHER;
                else                                       state_d = S_REPORT;
            end
            S_GATHER: if (src_hit && idx_last) state_d = S_OFFER;
            S_OFFER:  if (dst_ready) state_d = (left_q == LEN_W'(1)) ? S_REPORT : S_GATHER;
            S_REPORT: state_d = S_IDLE;
        endcase
    end

    // state and job registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            acc_q   <= '0;
            idx_q   <= '0;
            nsrc_q  <= '0;
            left_q  <= '0;
            tail_q  <= '0;
            irq_q   <= 1'b0;
            stat_q  <= ST_OK;
        end else begin
            state_q <= state_d;
            if (accept) begin
                irq_q  <= dec_irq;
                nsrc_q <= dec_nsrc;
                left_q <= map_words;
                tail_q <= map_tail;
                idx_q  <= '0;
                stat_q <= (dec_kind == K_BAD)   ? ST_BADCFG :
                          (dec_kind == K_UNSUP) ? ST_UNSUP  : ST_OK;
            end
            if (src_hit) begin
                acc_q <= (idx_q == '0) ? sel_word : (acc_q ^ sel_word);
                idx_q <= idx_last ? '0 : idx_q + CNT_W'(1);
            end
            if (state_q == S_OFFER && dst_ready) left_q <= left_q - LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        cmd_ready   = (state_q == S_IDLE);
        dst_valid   = (state_q == S_OFFER);
        dst_data    = acc_q;
        dst_last    = dst_valid && (left_q == LEN_W'(1));
        dst_strb    = dst_last ? tail_q : '1;
        done_pulse  = (state_q == S_REPORT);
        done_irq    = done_pulse && irq_q;
        done_status = done_pulse ? stat_q : ST_OK;
    end
endmodule

// File: rtl/xdp_checker.sv
`timescale 1ns/1ps
module xdp_checker #(
    parameter int DATA_W  = 32,
    parameter int MAX_SRC = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_ready,
    input logic [MAX_SRC-1:0]  src_ready,
    input logic                dst_valid,
    input logic [DATA_W-1:0]   dst_data,
    input logic [DATA_W/8-1:0] dst_strb,
    input logic                dst_last,
    input logic                dst_ready,
    input logic                done_pulse,
    input logic                done_irq
);
    // R11
    src_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));

    // R9
    dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && !dst_ready |=> dst_valid && $stable(dst_data)
                                    && $stable(dst_strb) && $stable(dst_last));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && dst_ready && dst_last |=> done_pulse);

    // R8
    irq_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> done_pulse);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !dst_valid && (src_ready == '0) && !done_pulse);
endmodule

bind xor_dma_core xdp_checker #(.DATA_W(DATA_W), .MAX_SRC(MAX_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .src_ready  (src_ready),
    .dst_valid  (dst_valid),
    .dst_data   (dst_data),
    .dst_strb   (dst_strb),
    .dst_last   (dst_last),
    .dst_ready  (dst_ready),
    .done_pulse (done_pulse),
    .done_irq   (done_irq)
);

// File: tb/xor_dma_core_test.sv
`timescale 1ns/1ps
module xor_dma_core_test;
    localparam int DW = 32;
    localparam int NS = 8;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [31:0]   cmd_ctrl = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [NS-1:0] src_valid = '1;
    logic [NS*DW-1:0] src_data;
    logic [NS-1:0] src_ready;
    logic          dst_valid;
    logic [DW-1:0] dst_data;
    logic [3:0]    dst_strb;
    logic          dst_last;
    logic          dst_ready = 1'b1;
    logic          done_pulse, done_irq;
    logic [1:0]    done_status;

    xor_dma_core #(.DATA_W(DW), .MAX_SRC(NS), .LEN_W(LW)) uut (.*);

    always #10 clk = ~clk;

    int vectors = 0, miscompares = 0;
    int cyc = 0;
    bit stall = 0;
    int cnt [NS];
    bit pend [NS];
    logic [DW-1:0] got_d [64];
    logic [3:0]    got_s [64];
    logic          got_l [64];
    int ndst = 0, last_hs_cyc = 0;
    int ndone = 0, done_cyc = 0;
    logic [1:0] got_st;
    logic got_irq;

    function automatic logic [31:0] pat(int s, int w);
        return {4'(s + 1), 12'(w * 37 + 5), 16'(32'hBEEF ^ (s * 4099) ^ (w * 257))};
    endfunction

    always_comb
        for (int s = 0; s < NS; s++) src_data[s*DW +: DW] = pat(s, cnt[s]);

    initial for (int s = 0; s < NS; s++) begin cnt[s] = 0; pend[s] = 0; end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        for (int s = 0; s < NS; s++) if (pend[s]) begin cnt[s] = cnt[s] + 1; pend[s] = 0; end
        #1;
        for (int s = 0; s < NS; s++) src_valid[s] = stall ? ((cyc + s) % 3 != 0) : 1'b1;
        dst_ready = stall ? (cyc % 2 == 1) : 1'b1;
    end

    always @(negedge clk) begin
        for (int s = 0; s < NS; s++) if (src_valid[s] && src_ready[s]) pend[s] = 1;
        if (dst_valid && dst_ready && ndst < 64) begin
            got_d[ndst] = dst_data; got_s[ndst] = dst_strb; got_l[ndst] = dst_last;
            ndst++; last_hs_cyc = cyc;
        end
        if (done_pulse) begin
            ndone++; done_cyc = cyc; got_st = done_status; got_irq = done_irq;
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #3000000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    task automatic run_job(string req, logic [31:0] ctrl, int len, int nsrc,
                           logic [1:0] st_exp, bit stl);
        int words, acc_cyc, wait_n;
        int rem;
        logic [31:0] exp;
        logic [3:0] es;
        words = (nsrc == 0) ? 0 : (len + 3) / 4;
        rem = len % 4;
        @(posedge clk); #3;
        for (int s = 0; s < NS; s++) cnt[s] = 0;
        ndst = 0; ndone = 0; stall = stl;
        cmd_ctrl = ctrl; cmd_len = LW'(len); cmd_valid = 1'b1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        acc_cyc = cyc;
        @(posedge clk); #3;
        cmd_valid = 1'b0;
        wait_n = 0;
        while (ndone == 0 && wait_n < 3000) begin @(negedge clk); wait_n++; end
        repeat (3) @(negedge clk);
        stall = 0;
        check(ndone == 1, req, "completion count", ndone, 1);
        check(got_st == st_exp, req, "status", got_st, st_exp);
        check(got_irq == ctrl[27], req, "done_irq", got_irq, ctrl[27]);
        check(ndst == words, req, "word count", ndst, words);
        check(done_cyc == ((words > 0) ? last_hs_cyc : acc_cyc) + 1, "R8", "done timing",
              done_cyc, ((words > 0) ? last_hs_cyc : acc_cyc) + 1);
        for (int w = 0; w < words && w < ndst; w++) begin
            exp = '0;
            for (int s = 0; s < nsrc; s++) exp ^= pat(s, w);
            es = (w == words - 1 && rem != 0) ? 4'((1 << rem) - 1) : 4'hF;
            check(got_d[w] == exp, req, "data", got_d[w], exp);
            check(got_s[w] == es, "R6", "strobe", got_s[w], es);
            check(got_l[w] == (w == words - 1), "R6", "last flag", got_l[w], (w == words - 1));
        end
        for (int s = 0; s < NS; s++)
            check(cnt[s] == ((s < nsrc) ? words : 0), req, $sformatf("src%0d reads", s),
                  cnt[s], (s < nsrc) ? words : 0);
    endtask

    localparam logic [31:0] PEN = 32'h1 << 17;
    localparam logic [31:0] IOD = 32'h1 << 27;
    function automatic logic [31:0] cw(int mode, int n);
        return (32'(mode) << 28) | (32'(n & 15) << 22);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10", "cmd_ready", cmd_ready, 1);
        check(dst_valid == 1'b0 && src_ready == '0, "R10", "idle outputs", {dst_valid, src_ready}, 0);
        check(done_pulse == 1'b0 && done_status == 2'b00, "R10", "idle done", done_pulse, 0);
    endtask

    task automatic t_copy();
        run_job("R2", cw(1, 3), 12, 1, 2'b00, 0);
        run_job("R2", cw(1, 0) | IOD, 10, 1, 2'b00, 1);
    endtask

    task automatic t_parity();
        run_job("R3", cw(6, 3) | PEN, 16, 3, 2'b00, 0);
        run_job("R3", cw(6, 8) | PEN | IOD, 7, 8, 2'b00, 1);
        run_job("R5", cw(6, 1) | PEN, 4, 1, 2'b00, 1);
        run_job("R5", cw(6, 5) | PEN, 21, 5, 2'b00, 0);
    endtask

    task automatic t_reject();
        run_job("R4", cw(6, 0) | PEN | IOD, 8, 0, 2'b01, 0);
        run_job("R4", cw(6, 9) | PEN, 8, 0, 2'b01, 0);
        run_job("R4", cw(6, 3), 8, 0, 2'b01, 0);
    endtask

    task automatic t_dataless();
        run_job("R7", cw(0, 2) | IOD, 16, 0, 2'b00, 0);
        run_job("R1", cw(5, 2) | PEN, 16, 0, 2'b10, 0);
        run_job("R1", cw(8, 2) | PEN | IOD, 16, 0, 2'b10, 0);
        run_job("R1", cw(2, 1), 4, 0, 2'b10, 0);
        run_job("R5", cw(6, 2) | PEN, 0, 0, 2'b00, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        t_reset();
        t_copy();
        t_parity();
        t_reject();
        t_dataless();
        t_reset();
        summary();
    end
endmodule